// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a pipelined synchronous static RAM. It has a common data path of byte lanes, which is modelled as a separate write-data input, a registered read-data output and a drive-enable output in place of a bidirectional pad. An access starts when one of two address strobes is sampled low while the device is selected. The processor strobe has priority and starts an access whose write, if there is one, completes on the following edge. The controller strobe starts an access whose write completes on the same edge. Read data passes through an output register and appears one cycle after the access address is captured. A 2-bit burst position, loaded from the two lowest address bits, steps through a linear or an interleaved four-beat wrap on each edge where advance is low.

Byte-masked writes leave unselected lanes untouched. The drive-enable is forced low on the first cycle after reselection, after a deselecting strobe, and while any write control is asserted. An asynchronous sleep input is synchronised into a low-power state that takes two clocks to enter and two clocks to leave. Stored contents survive sleep. Every strobe is ignored while the device is asleep.

The data interface is a plain memory port with no valid/ready handshake. It cannot stall: read data is present in the cycle fixed by the pipeline, and write data is taken on the edge where the write completes.

Top module: `burst_sram`

## Requirements
- R1: An edge with the processor strobe low and all three chip enables active (primary low, high-active enable high, low-active enable low) captures the address. Data from that address is in the output register after the next edge. It is driven (`dq_oe` high) in that cycle only when `oe_n` is low and the previous cycle already had an active access.
- R2: The processor strobe has no effect when `ce_pri_n` is high. It neither starts nor ends an access, and a running access continues as if no strobe were present.
- R3: In the cycle after an access starts from the deselected state, `dq_oe` is low whatever the level of `oe_n`.
- R4: An edge where a strobe that is taken into account samples at least one chip enable inactive deselects the device. From the cycle after that edge, `dq_oe` is low until a new access has run for one cycle.
- R5: On the starting edge of a processor-strobe access, write controls and `adv_n` are ignored. On a later edge, `gw_n` low writes all lanes. Otherwise `bwe_n` low writes each lane i whose `bsel_n[i]` is low.
- R6: A controller-strobe access, with `cpu_strobe_n` high or ignored, writes `dq_in` to `addr` on its own starting edge when the write controls select at least one lane. Otherwise it starts a read.
- R7: Lane i is bits 8i+7..8i. A lane that a write does not select keeps its previous contents.
- R8: While `gw_n` is low, or `bwe_n` is low with any `bsel_n` bit low, `dq_oe` is low. After an edge that performed a write, `dq_oe` is low for the next cycle.
- R9: With `mode` low the burst position is (start + n) mod 4, and with `mode` high it is start XOR n, where n counts `adv_n`-low edges since the access began. The upper address bits never change in a burst. On a continuing edge, a write goes to the advanced position when `adv_n` is low and to the current position when it is high.
- R10: The device sleeps from the second edge after `zz` rises until the second edge after it falls. While it sleeps, strobes are ignored and no write occurs. From the cycle after the first sleeping edge, `dq_oe` is low. After waking, memory holds its earlier contents.
- R11: When both strobes are low on a selected edge, the access is a processor-strobe start, so no write happens on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, priority |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| ce_pri_n | input | 1 | Primary chip enable, active low, gates processor strobe |
| ce_hi | input | 1 | Chip enable, active high |
| ce_lo_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| zz | input | 1 | Asynchronous sleep request, active high |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Data drive enable |

## Verification
The bench builds the block with ADDR_W = 6, a 64-word array with four 8-bit lanes. At that depth it can fill every word first, so every random read after the fill compares against a known reference. Bursts starting at each position, and wraps inside the top and bottom 4-word groups, come up often in a few thousand random cycles. The default lane count and width keep the lane encoding of R7 unchanged.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int BURST_W = 2;
  typedef logic [BURST_W-1:0] burst_t;

  // Position within a four-beat wrap for a given start and beat count.
  function automatic burst_t burst_pos(burst_t start, burst_t beat, logic interleave);
    burst_t sum;
    sum = burst_t'(start + beat);
    return interleave ? (start ^ beat) : sum;
  endfunction
endpackage

// File: rtl/sbsram_sleep_sync.sv
module sbsram_sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zz_async,
  output logic asleep
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], zz_async};
  end

  assign asleep = pipe_q[STAGES-1];
endmodule

// File: rtl/sbsram_burst_ctr.sv
module sbsram_burst_ctr
  import sbsram_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  burst_t load_pos,
  input  logic   step,
  input  logic   interleave,
  output burst_t cur_pos,
  output burst_t nxt_pos
);
  burst_t start_q, beat_q, beat_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      start_q <= load_pos;
      beat_q  <= '0;
    end else if (step) begin
      beat_q  <= beat_nx;
    end
  end

  assign beat_nx = burst_t'(beat_q + 1'b1);
  assign cur_pos = burst_pos(start_q, beat_q, interleave);
  assign nxt_pos = burst_pos(start_q, beat_nx, interleave);

  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> (!$stable(interleave) || $stable(cur_pos))) else $error("burst moved without advance"); // R9

  AST_BURST_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (!$stable(interleave) || (cur_pos != $past(cur_pos)))) else $error("advance did not move burst"); // R9
endmodule

// File: rtl/sbsram_lane_array.sv
module sbsram_lane_array #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wr_lanes[g]) bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q[g*LANE_W +: LANE_W] <= '0;
      else        rd_q[g*LANE_W +: LANE_W] <= bank[rd_addr];
    end
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cpu_strobe_n,
  input  logic                    ctl_strobe_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic                    ce_pri_n,
  input  logic                    ce_hi,
  input  logic                    ce_lo_n,
  input  logic                    oe_n,
  input  logic                    mode,
  input  logic                    zz,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic asleep, awake;
  logic sel, p_go, c_go, p_start, c_start, start, desel, cont, step;
  logic [LANES-1:0] lane_pick;
  logic wr_any, wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [HI_W-1:0] hi_q;
  logic active_q, valid_q;
  burst_t cur_pos, nxt_pos;

  sbsram_sleep_sync #(.STAGES(2)) u_sleep (
    .clk(clk), .rst_n(rst_n), .zz_async(zz), .asleep(asleep)
  );

  // Access decode
  always_comb begin
    awake     = !asleep;
    sel       = !ce_pri_n && ce_hi && !ce_lo_n;
    p_go      = awake && !cpu_strobe_n && !ce_pri_n;
    c_go      = awake && !ctl_strobe_n && !p_go;
    p_start   = p_go && sel;
    c_start   = c_go && sel;
    start     = p_start || c_start;
    desel     = (p_go || c_go) && !sel;
    cont      = awake && active_q && !p_go && !c_go;
    step      = cont && !adv_n;
    lane_pick = gw_n ? (~bsel_n & {LANES{!bwe_n}}) : {LANES{1'b1}};
    wr_any    = |lane_pick;
    wr_en     = wr_any && (c_start || cont);
    wr_addr   = c_start ? addr : {hi_q, (step ? nxt_pos : cur_pos)};
    rd_addr   = {hi_q, cur_pos};
  end

  sbsram_burst_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .load(start), .load_pos(addr[BURST_W-1:0]),
    .step(step), .interleave(mode), .cur_pos(cur_pos), .nxt_pos(nxt_pos)
  );

  sbsram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .wr_addr(wr_addr), .wr_lanes(lane_pick),
    .wr_data(dq_in), .rd_addr(rd_addr), .rd_q(dq_out)
  );

  // Access state and output validity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      active_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      if (start) hi_q <= addr[ADDR_W-1:BURST_W];
      if (!awake)     active_q <= 1'b0;
      else if (start) active_q <= 1'b1;
      else if (desel) active_q <= 1'b0;
      valid_q <= awake && active_q && !wr_any && !desel;
    end
  end

  assign dq_oe = valid_q && !oe_n && !wr_any;

  AST_FIRST_CYCLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> !dq_oe) else $error("drive on first cycle"); // R3

  AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !dq_oe) else $error("drive after deselect"); // R4

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !dq_oe) else $error("drive after write"); // R8

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> !dq_oe) else $error("drive while asleep"); // R10

  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !wr_en) else $error("write while asleep"); // R10
endmodule

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  localparam int CLK_P  = 10;
  localparam int AW     = 6;
  localparam int DEPTH  = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr;
  logic cpu_strobe_n, ctl_strobe_n, adv_n, gw_n, bwe_n;
  logic [3:0] bsel_n;
  logic ce_pri_n, ce_hi, ce_lo_n, oe_n, mode, zz;
  logic [31:0] dq_in, dq_out;
  logic dq_oe;

  burst_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strobe_n(cpu_strobe_n),
    .ctl_strobe_n(ctl_strobe_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bsel_n(bsel_n), .ce_pri_n(ce_pri_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .oe_n(oe_n), .mode(mode), .zz(zz), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // Reference model state
  logic [31:0] ref_mem [DEPTH];
  bit m_act, m_valid, m_z1, m_z2;
  logic [31:0] m_out;
  logic [AW-3:0] m_hi;
  logic [1:0] m_start, m_beat;

  function automatic logic [1:0] pos_of(logic [1:0] s, logic [1:0] n, logic il);
    logic [1:0] lin;
    lin = (s + n) & 2'b11;
    return il ? (s ^ n) : lin;
  endfunction

  function automatic logic [3:0] lanes_now();
    if (!gw_n) return 4'hF;
    if (!bwe_n) return ~bsel_n;
    return 4'h0;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    addr = 0; cpu_strobe_n = 1; ctl_strobe_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1;
    bsel_n = 4'hF; ce_pri_n = 0; ce_hi = 1; ce_lo_n = 0; oe_n = 0; zz = 0; dq_in = 0;
  endtask

  task automatic model_edge();
    bit asl, sel, pgo, cgo, ps, cs, st, ds, ct, stp, wa;
    logic [3:0] ln;
    logic [1:0] lo, nlo;
    logic [AW-1:0] wa_addr;
    logic [31:0] rd, old;
    asl = m_z2; m_z2 = m_z1; m_z1 = zz;
    sel = !ce_pri_n && ce_hi && !ce_lo_n;
    pgo = !asl && !cpu_strobe_n && !ce_pri_n;
    cgo = !asl && !ctl_strobe_n && !pgo;
    ps = pgo && sel; cs = cgo && sel; st = ps || cs;
    ds = (pgo || cgo) && !sel;
    ct = !asl && m_act && !pgo && !cgo;
    stp = ct && !adv_n;
    ln = lanes_now(); wa = (ln != 0);
    lo = pos_of(m_start, m_beat, mode);
    nlo = pos_of(m_start, 2'(m_beat + 1), mode);
    rd = ref_mem[{m_hi, lo}];
    if (wa && (cs || ct)) begin
      wa_addr = cs ? addr : {m_hi, (stp ? nlo : lo)};
      old = ref_mem[wa_addr];
      for (int i = 0; i < 4; i++)
        if (ln[i]) old[i*8 +: 8] = dq_in[i*8 +: 8];
      ref_mem[wa_addr] = old;
    end
    m_valid = !asl && m_act && !wa && !ds;
    m_out = rd;
    if (st) begin m_hi = addr[AW-1:2]; m_start = addr[1:0]; m_beat = 0; end
    else if (stp) m_beat = 2'(m_beat + 1);
    if (asl) m_act = 0; else if (st) m_act = 1; else if (ds) m_act = 0;
  endtask

  // Inputs already applied after a falling edge; check, then clock.
  task automatic cyc(string tag);
    bit exp_oe;
    #1;
    exp_oe = m_valid && !oe_n && (lanes_now() == 0);
    check(dq_oe == exp_oe, {tag, " drive"}, {31'd0, dq_oe}, {31'd0, exp_oe});
    if (exp_oe) check(dq_out == m_out, {tag, " data"}, dq_out, m_out);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic go_deselect();
    idle(); ctl_strobe_n = 0; ce_hi = 0; cyc("R4");
    idle(); cyc("R4");
  endtask

  task automatic rd_burst(logic [AW-1:0] a, bit md, string tag);
    idle(); mode = md; addr = a; cpu_strobe_n = 0; cyc(tag);
    for (int k = 0; k < 5; k++) begin idle(); mode = md; adv_n = 0; cyc(tag); end
    idle(); mode = md; cyc(tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd1234));
    idle(); mode = 0;
    m_act = 0; m_valid = 0; m_z1 = 0; m_z2 = 0; m_out = 0; m_hi = 0; m_start = 0; m_beat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(dq_oe == 0, "reset R3", {31'd0, dq_oe}, 32'd0);
    @(negedge clk);

    // Fill every word with single-edge controller-strobe writes (R6)
    for (int a = 0; a < DEPTH; a++) begin
      idle(); addr = AW'(a); ctl_strobe_n = 0; gw_n = 0; dq_in = {8'(a), 8'(a ^ 8'h5A), 8'(a + 3), 8'(~a)};
      cyc("R6");
    end
    go_deselect();

    // Single read from deselected state: first cycle quiet (R3), then data (R1)
    idle(); addr = 6'd5; cpu_strobe_n = 0; cyc("R3");
    idle(); cyc("R1"); idle(); oe_n = 1; cyc("R1"); idle(); cyc("R1");
    // Consecutive single reads
    for (int a = 9; a < 13; a++) begin idle(); addr = AW'(a); cpu_strobe_n = 0; cyc("R1"); end
    idle(); cyc("R1");

    // Burst orders, including top group wrap (R9)
    rd_burst(6'd13, 1'b0, "R9");
    rd_burst(6'd22, 1'b1, "R9");
    rd_burst(6'd63, 1'b0, "R9");
    rd_burst(6'd61, 1'b1, "R9");

    // Processor-strobe write: controls ignored on start edge, byte write next (R5, R7)
    idle(); addr = 6'd8; cpu_strobe_n = 0; gw_n = 0; dq_in = 32'hDEADBEEF; cyc("R5");
    idle(); bwe_n = 0; bsel_n = 4'b1010; dq_in = 32'h11223344; cyc("R7");
    idle(); adv_n = 0; gw_n = 0; dq_in = 32'hCAFEF00D; cyc("R9");
    idle(); bwe_n = 0; bsel_n = 4'hF; cyc("R8");
    idle(); oe_n = 0; gw_n = 0; dq_in = 32'h0BADF00D; cyc("R8");
    idle(); cyc("R8"); idle(); cyc("R8");
    idle(); addr = 6'd8; cpu_strobe_n = 0; cyc("R7");
    idle(); adv_n = 0; cyc("R7"); idle(); cyc("R7"); idle(); cyc("R7");

    // Processor strobe ignored with primary enable high (R2)
    idle(); addr = 6'd40; cpu_strobe_n = 0; ce_pri_n = 1; adv_n = 0; cyc("R2");
    idle(); cyc("R2"); idle(); cyc("R2");
    go_deselect();
    idle(); addr = 6'd40; cpu_strobe_n = 0; ce_pri_n = 1; cyc("R2");
    idle(); cyc("R2"); idle(); cyc("R2");

    // Both strobes low: processor-strobe start, no write (R11)
    idle(); addr = 6'd30; cpu_strobe_n = 0; ctl_strobe_n = 0; gw_n = 0; dq_in = 32'hFFFF0000; cyc("R11");
    idle(); cyc("R11"); idle(); cyc("R11");
    idle(); addr = 6'd30; cpu_strobe_n = 0; cyc("R11"); idle(); cyc("R11"); idle(); cyc("R11");

    // Controller strobe byte write then read (R6, R7)
    idle(); addr = 6'd33; ctl_strobe_n = 0; bwe_n = 0; bsel_n = 4'b0110; dq_in = 32'hA1B2C3D4; cyc("R6");
    idle(); cyc("R6"); idle(); cyc("R6");

    // Sleep: deselect, sleep, try a write, wake, read back (R10)
    go_deselect();
    for (int k = 0; k < 6; k++) begin idle(); zz = 1; cyc("R10"); end
    idle(); zz = 1; addr = 6'd3; ctl_strobe_n = 0; gw_n = 0; dq_in = 32'h12345678; cyc("R10");
    idle(); zz = 1; cyc("R10");
    for (int k = 0; k < 4; k++) begin idle(); cyc("R10"); end
    idle(); addr = 6'd3; cpu_strobe_n = 0; cyc("R10");
    idle(); cyc("R10"); idle(); cyc("R10");

    // Constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      idle();
      w = $urandom;
      addr = AW'($urandom);
      cpu_strobe_n = (w[3:0] > 4'd3);
      ctl_strobe_n = (w[7:4] > 4'd4);
      adv_n = w[8];
      ce_pri_n = (w[12:9] == 0);
      ce_hi = (w[16:13] != 0);
      ce_lo_n = (w[20:17] == 0);
      gw_n = (w[23:21] != 0);
      bwe_n = (w[25:24] == 0) ? 1'b0 : 1'b1;
      bsel_n = 4'($urandom);
      oe_n = (w[28:26] == 0);
      mode = w[29];
      dq_in = $urandom;
      cyc("R1");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule